// File: doc/BRIEF.md
# Boot-Remappable System Address Decoder

This block sits between the single bus master of a small system and its memories and peripherals. Every valid request address is compared against a fixed set of windows. One clock later the block presents a one-hot target select, the offset of the access inside the chosen target, or a decode-error flag. The targets are:

- SRAM at the bottom of the address space
- a 4 KiB boot ROM
- a parallel flash device
- a board-control register block
- three network-controller windows: registers, descriptors and packet buffer
- a UART

All peripherals live inside a 224 MiB I/O window that starts at 0xF000_0000.

The boot region at 0xFE00_0000 can be remapped. A boot-mode pin is captured while reset is held. When the pin is high, the whole flash device shows through at the boot region. When it is low, the small internal ROM stays there. The flash can always be reached at its own direct address, 0xF800_0000. A parameter picks one of two board variants: variant 0 has 4 MiB of flash and 128 KiB of SRAM, and variant 1 has 16 MiB of flash and 32 MiB of SRAM.

Top module: `boot_remap_decoder`

## Requirements
- R1: An address below the SRAM size (0x2_0000 in variant 0, 0x200_0000 in variant 1) drives select bit 0, and the offset equals the address.
- R2: With the boot pin low at reset, the range 0xFE00_0000 to 0xFE00_0FFF drives select bit 1 with offset address minus 0xFE00_0000. Addresses from 0xFE00_1000 upward outside every other window are decode errors.
- R3: With the boot pin high at reset, the range from 0xFE00_0000 through the flash size drives select bit 2 with offset address minus 0xFE00_0000. Select bit 1 is never driven in that mode.
- R4: The range from 0xF800_0000 through the flash size drives select bit 2 with offset address minus 0xF800_0000, whatever the boot mode.
- R5: The 64 KiB range at 0xFD02_0000 drives select bit 3 with the offset inside the block.
- R6: Three network windows decode as follows, each with its local offset:
  - 1 KiB of registers at 0xFD03_0000 drives select bit 4.
  - 1 KiB of descriptors at 0xFD03_0400 drives select bit 5.
  - 16 KiB of packet buffer at 0xFD80_0000 drives select bit 6.
- R7: The 32-byte range at 0xFD05_0020 drives select bit 7. The offset is the register index, which is the byte offset shifted right by 2.
- R8: An address that hits no window raises the decode error with all selects low and a zero offset.
- R9: Outputs appear on the clock edge after the request is sampled. A cycle with no valid request gives all selects low, no error and a zero offset.
- R10: The boot pin is sampled only while reset is asserted. Changing it after reset has no effect on decoding.
- R11: While reset is asserted, all selects, the offset and the error flag are zero.
- R12: At most one select bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| boot_flash_i | input | 1 | Boot-mode pin: 1 maps flash over the boot region, 0 keeps the ROM |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 32 | Request byte address |
| tgt_sel_o | output | 8 | One-hot target select (bit order SRAM, ROM, flash, board, net regs, net desc, net buffer, UART) |
| tgt_off_o | output | 32 | Offset local to the selected target |
| dec_err_o | output | 1 | Decode error: no target hit |

## Verification
The sweep probes each window at one below its base, at its base, one above its base, at its middle, at its last byte and one past its end. An off-by-one limit would therefore claim a neighbour's address or drop its own last byte. The probes run under both boot modes. A remap that ignored the latched mode would return the ROM where the flash alias belongs, or would leave the 4 KiB to 4 MiB part of the boot region decoding as an error. After reset the boot pin is toggled to catch a design that tracks the live pin. Dense pseudo-random addresses around the peripheral cluster expose a UART offset left unshifted and any select that leaks into the gaps between peripherals.

// File: rtl/brd_pkg.sv
package brd_pkg;

   localparam int NUM_TGT = 8;
   localparam int NUM_WIN = 9;
   localparam int TGT_W   = 3;

   typedef enum logic [TGT_W-1:0] {
      TGT_SRAM    = 3'd0,
      TGT_ROM     = 3'd1,
      TGT_FLASH   = 3'd2,
      TGT_BOARD   = 3'd3,
      TGT_NETREG  = 3'd4,
      TGT_NETDESC = 3'd5,
      TGT_NETBUF  = 3'd6,
      TGT_UART    = 3'd7
   } tgt_e;

   localparam logic [31:0] IO_BASE    = 32'hF000_0000;
   localparam logic [31:0] BOOT_BASE  = 32'hFE00_0000;
   localparam logic [31:0] FLASH_BASE = 32'hF800_0000;
   localparam logic [31:0] ROM_BYTES  = 32'h0000_1000;

   // 0: any boot mode, 1: only when booting from flash, 2: only when booting from ROM
   localparam int GATE_ANY   = 0;
   localparam int GATE_FLASH = 1;
   localparam int GATE_ROM   = 2;

   function automatic logic [31:0] flash_bytes(input int variant);
      return (variant == 0) ? 32'h0040_0000 : 32'h0100_0000;
   endfunction

   function automatic logic [31:0] sram_bytes(input int variant);
      return (variant == 0) ? 32'h0002_0000 : 32'h0200_0000;
   endfunction

   // Windows are listed highest priority first.
   function automatic logic [31:0] win_base(input int w);
      case (w)
         0, 1:    return BOOT_BASE;
         2:       return IO_BASE + 32'h0D02_0000;
         3:       return IO_BASE + 32'h0D03_0000;
         4:       return IO_BASE + 32'h0D03_0400;
         5:       return IO_BASE + 32'h0D80_0000;
         6:       return IO_BASE + 32'h0D05_0020;
         7:       return FLASH_BASE;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [31:0] win_size(input int w, input int variant);
      case (w)
         0:       return flash_bytes(variant);
         1:       return ROM_BYTES;
         2:       return 32'h0001_0000;
         3, 4:    return 32'h0000_0400;
         5:       return 32'h0000_4000;
         6:       return 32'h0000_0020;
         7:       return flash_bytes(variant);
         default: return sram_bytes(variant);
      endcase
   endfunction

   function automatic tgt_e win_tgt(input int w);
      case (w)
         0:       return TGT_FLASH;
         1:       return TGT_ROM;
         2:       return TGT_BOARD;
         3:       return TGT_NETREG;
         4:       return TGT_NETDESC;
         5:       return TGT_NETBUF;
         6:       return TGT_UART;
         7:       return TGT_FLASH;
         default: return TGT_SRAM;
      endcase
   endfunction

   function automatic int win_gate(input int w);
      case (w)
         0:       return GATE_FLASH;
         1:       return GATE_ROM;
         default: return GATE_ANY;
      endcase
   endfunction

   function automatic logic [NUM_WIN*TGT_W-1:0] tgt_map();
      logic [NUM_WIN*TGT_W-1:0] m;
      m = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         m[w*TGT_W +: TGT_W] = win_tgt(w);
      end
      return m;
   endfunction

endpackage

// File: rtl/brd_boot_latch.sv
module brd_boot_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic boot_pin_i,
   output logic boot_flash_o
);

   logic mode_q;

   // Follows the pin only during reset; frozen once reset is released.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= boot_pin_i;
      end
   end

   assign boot_flash_o = mode_q;

endmodule

// File: rtl/brd_window.sv
module brd_window #(
   parameter int          ADDR_W = 32,
   parameter logic [31:0] BASE   = 32'h0,
   parameter logic [31:0] SIZE   = 32'h1000,
   parameter int          SHIFT  = 0
) (
   input  logic              en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [ADDR_W-1:0] off_o
);

   localparam logic [32:0] LIMIT = {1'b0, BASE} + {1'b0, SIZE};

   if (SIZE == 32'h0) begin : g_bad_size
      $error("brd_window: window size must be nonzero");
   end
   if (LIMIT > 33'h1_0000_0000) begin : g_bad_limit
      $error("brd_window: window runs past the top of the address space");
   end
   if (SHIFT < 0 || SHIFT > 4) begin : g_bad_shift
      $error("brd_window: offset shift out of range");
   end

   logic [ADDR_W:0] delta;

   always_comb begin
      delta = {1'b0, addr_i} - {1'b0, BASE};
      hit_o = en_i && !delta[ADDR_W] && (delta < {1'b0, SIZE});
      off_o = delta[ADDR_W-1:0] >> SHIFT;
   end

endmodule

// File: rtl/brd_pick.sv
module brd_pick #(
   parameter int                  NUM_WIN = 9,
   parameter int                  NUM_TGT = 8,
   parameter int                  TGT_W   = 3,
   parameter int                  ADDR_W  = 32,
   parameter logic [NUM_WIN*TGT_W-1:0] TGT_MAP = '0
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            valid_i,
   input  logic [NUM_WIN-1:0]              hit_i,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0]  off_i,
   output logic [NUM_TGT-1:0]              sel_o,
   output logic [ADDR_W-1:0]               off_o,
   output logic                            err_o
);

   if ((1 << TGT_W) < NUM_TGT) begin : g_bad_tgt_w
      $error("brd_pick: target code too narrow");
   end

   logic [NUM_TGT-1:0] sel_d;
   logic [ADDR_W-1:0]  off_d;
   logic               any_d;

   // Scan from lowest priority upward so the highest-priority hit is kept.
   always_comb begin
      sel_d = '0;
      off_d = '0;
      any_d = 1'b0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (hit_i[w]) begin
            sel_d = '0;
            sel_d[TGT_MAP[w*TGT_W +: TGT_W]] = 1'b1;
            off_d = off_i[w];
            any_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sel_o <= '0;
         off_o <= '0;
         err_o <= 1'b0;
      end else if (valid_i) begin
         sel_o <= sel_d;
         off_o <= off_d;
         err_o <= !any_d;
      end else begin
         sel_o <= '0;
         off_o <= '0;
         err_o <= 1'b0;
      end
   end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder #(
   parameter int VARIANT    = 0,
   parameter int ADDR_W     = 32,
   parameter int UART_SHIFT = 2
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         boot_flash_i,
   input  logic                         req_valid_i,
   input  logic [ADDR_W-1:0]            req_addr_i,
   output logic [brd_pkg::NUM_TGT-1:0]  tgt_sel_o,
   output logic [ADDR_W-1:0]            tgt_off_o,
   output logic                         dec_err_o
);
   import brd_pkg::*;

   localparam logic [NUM_WIN*TGT_W-1:0] MAP = tgt_map();

   if (VARIANT != 0 && VARIANT != 1) begin : g_bad_variant
      $error("boot_remap_decoder: VARIANT must be 0 or 1");
   end
   if (ADDR_W != 32) begin : g_bad_addr_w
      $error("boot_remap_decoder: only a 32-bit address is supported");
   end
   if (sram_bytes(VARIANT) > FLASH_BASE) begin : g_bad_sram
      $error("boot_remap_decoder: SRAM window reaches the flash window");
   end

   logic                           boot_flash_q;
   logic [NUM_WIN-1:0]             hit;
   logic [NUM_WIN-1:0][ADDR_W-1:0] off;

   brd_boot_latch u_boot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .boot_pin_i   (boot_flash_i),
      .boot_flash_o (boot_flash_q)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam int GATE = win_gate(w);
      logic en;

      if (GATE == GATE_FLASH) begin : g_flash_only
         assign en = boot_flash_q;
      end else if (GATE == GATE_ROM) begin : g_rom_only
         assign en = !boot_flash_q;
      end else begin : g_always
         assign en = 1'b1;
      end

      brd_window #(
         .ADDR_W (ADDR_W),
         .BASE   (win_base(w)),
         .SIZE   (win_size(w, VARIANT)),
         .SHIFT  ((win_tgt(w) == TGT_UART) ? UART_SHIFT : 0)
      ) u_win (
         .en_i   (en),
         .addr_i (req_addr_i),
         .hit_o  (hit[w]),
         .off_o  (off[w])
      );
   end

   brd_pick #(
      .NUM_WIN (NUM_WIN),
      .NUM_TGT (NUM_TGT),
      .TGT_W   (TGT_W),
      .ADDR_W  (ADDR_W),
      .TGT_MAP (MAP)
   ) u_pick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (req_valid_i),
      .hit_i   (hit),
      .off_i   (off),
      .sel_o   (tgt_sel_o),
      .off_o   (tgt_off_o),
      .err_o   (dec_err_o)
   );

endmodule

// File: rtl/brd_checker.sv
module brd_checker #(
   parameter int VARIANT = 0,
   parameter int ADDR_W  = 32
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        req_valid_i,
   input  logic [ADDR_W-1:0]           req_addr_i,
   input  logic [brd_pkg::NUM_TGT-1:0] tgt_sel_o,
   input  logic [ADDR_W-1:0]           tgt_off_o,
   input  logic                        dec_err_o,
   input  logic                        boot_flash_q
);
   import brd_pkg::*;

   localparam logic [ADDR_W-1:0] SRAM_LIM = sram_bytes(VARIANT);

   AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(tgt_sel_o)); // R12

   AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_err_o |-> (tgt_sel_o == '0 && tgt_off_o == '0)); // R8

   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> (tgt_sel_o == '0 && !dec_err_o && tgt_off_o == '0)); // R9

   AST_VALID_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> (tgt_sel_o != '0 || dec_err_o)); // R9

   AST_BOOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> $stable(boot_flash_q)); // R10

   AST_ROM_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgt_sel_o[TGT_ROM] |-> !boot_flash_q); // R3

   AST_SRAM_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_addr_i < SRAM_LIM) |=>
         (tgt_sel_o[TGT_SRAM] && tgt_off_o == $past(req_addr_i))); // R1

   AST_UART_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgt_sel_o[TGT_UART] |-> (tgt_off_o < 8)); // R7

   AST_ROM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgt_sel_o[TGT_ROM] |-> (tgt_off_o < ROM_BYTES)); // R2

endmodule

bind boot_remap_decoder brd_checker #(
   .VARIANT (VARIANT),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_valid_i  (req_valid_i),
   .req_addr_i   (req_addr_i),
   .tgt_sel_o    (tgt_sel_o),
   .tgt_off_o    (tgt_off_o),
   .dec_err_o    (dec_err_o),
   .boot_flash_q (boot_flash_q)
);

// File: tb/boot_remap_decoder_bench.sv
module boot_remap_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        boot_pin;
   logic        valid;
   logic [31:0] addr;
   logic [7:0]  sel;
   logic [31:0] off;
   logic        err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit bf_ref;

   always #5 clk = ~clk;

   boot_remap_decoder #(.VARIANT(0)) u_boot_remap_decoder (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .boot_flash_i (boot_pin),
      .req_valid_i  (valid),
      .req_addr_i   (addr),
      .tgt_sel_o    (sel),
      .tgt_off_o    (off),
      .dec_err_o    (err)
   );

   // Variant 0 constants, taken from the requirements.
   localparam logic [31:0] SRAM_SZ  = 32'h0002_0000;
   localparam logic [31:0] FLASH_SZ = 32'h0040_0000;

   function automatic bit in_win(logic [31:0] a, logic [31:0] b, logic [31:0] s);
      return (a >= b) && ({1'b0, a} < {1'b0, b} + {1'b0, s});
   endfunction

   task automatic ref_model(input logic [31:0] a, input bit bf,
                            output logic [7:0] es, output logic [31:0] eo,
                            output logic ee, output string tag);
      es = '0; eo = '0; ee = 1'b0;
      if (bf && in_win(a, 32'hFE00_0000, FLASH_SZ)) begin
         es[2] = 1'b1; eo = a - 32'hFE00_0000; tag = "R3";
      end else if (!bf && in_win(a, 32'hFE00_0000, 32'h1000)) begin
         es[1] = 1'b1; eo = a - 32'hFE00_0000; tag = "R2";
      end else if (in_win(a, 32'hFD02_0000, 32'h1_0000)) begin
         es[3] = 1'b1; eo = a - 32'hFD02_0000; tag = "R5";
      end else if (in_win(a, 32'hFD03_0000, 32'h400)) begin
         es[4] = 1'b1; eo = a - 32'hFD03_0000; tag = "R6";
      end else if (in_win(a, 32'hFD03_0400, 32'h400)) begin
         es[5] = 1'b1; eo = a - 32'hFD03_0400; tag = "R6";
      end else if (in_win(a, 32'hFD80_0000, 32'h4000)) begin
         es[6] = 1'b1; eo = a - 32'hFD80_0000; tag = "R6";
      end else if (in_win(a, 32'hFD05_0020, 32'h20)) begin
         es[7] = 1'b1; eo = (a - 32'hFD05_0020) / 4; tag = "R7";
      end else if (in_win(a, 32'hF800_0000, FLASH_SZ)) begin
         es[2] = 1'b1; eo = a - 32'hF800_0000; tag = "R4";
      end else if (a < SRAM_SZ) begin
         es[0] = 1'b1; eo = a; tag = "R1";
      end else begin
         ee = 1'b1; tag = "R8";
      end
   endtask

   task automatic check(input string tag, input logic [31:0] a,
                        input logic [7:0] es, input logic [31:0] eo, input logic ee);
      checks++;
      if (sel !== es || off !== eo || err !== ee) begin
         fails++;
         $display("FAIL %s addr=%h sel=%b exp=%b off=%h exp=%h err=%b exp=%b",
                  tag, a, sel, es, off, eo, err, ee);
      end
   endtask

   task automatic probe(input logic [31:0] a);
      logic [7:0]  es;
      logic [31:0] eo;
      logic        ee;
      string       tag;
      @(negedge clk);
      valid = 1'b1;
      addr  = a;
      @(negedge clk);
      ref_model(a, bf_ref, es, eo, ee, tag);
      check(tag, a, es, eo, ee);
   endtask

   task automatic edges(input logic [31:0] b, input logic [31:0] s);
      probe(b - 1);
      probe(b);
      probe(b + 1);
      probe(b + s / 2);
      probe(b + s - 1);
      probe(b + s);
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk);
      rst_n    = 1'b0;
      boot_pin = mode;
      valid    = 1'b1;
      addr     = 32'h0000_0010;
      repeat (3) @(negedge clk);
      check("R11", addr, 8'h00, 32'h0, 1'b0);
      rst_n  = 1'b1;
      bf_ref = mode;
   endtask

   task automatic sweep();
      logic [31:0] r;
      edges(32'h0000_0000, SRAM_SZ);
      edges(32'hFE00_0000, 32'h1000);
      edges(32'hFE00_0000, FLASH_SZ);
      edges(32'hF800_0000, FLASH_SZ);
      edges(32'hFD02_0000, 32'h1_0000);
      edges(32'hFD03_0000, 32'h400);
      edges(32'hFD03_0400, 32'h400);
      edges(32'hFD80_0000, 32'h4000);
      edges(32'hFD05_0020, 32'h20);
      for (int i = 0; i < 32; i++) probe(32'hFD05_0020 + i);
      probe(32'hF000_0000);
      probe(32'hFFFF_FFFF);
      r = 32'h1234_5679;
      for (int i = 0; i < 1600; i++) begin
         r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
         case (i % 4)
            0: probe(r);
            1: probe(32'hFD00_0000 | (r & 32'h0087_0FFF));
            2: probe(r & 32'h0003_FFFF);
            default: probe(32'hFE00_0000 | (r & 32'h007F_FFFF));
         endcase
      end
   endtask

   initial begin
      rst_n    = 1'b0;
      boot_pin = 1'b0;
      valid    = 1'b0;
      addr     = '0;
      bf_ref   = 1'b0;

      // Boot from ROM
      do_reset(1'b0);
      sweep();

      // R9: an idle cycle after a valid hit gives zeros
      probe(32'h0000_0100);
      @(negedge clk);
      valid = 1'b0;
      addr  = 32'h0000_0200;
      @(negedge clk);
      check("R9", addr, 8'h00, 32'h0, 1'b0);

      // R10: toggling the pin after reset changes nothing
      @(negedge clk);
      boot_pin = 1'b1;
      repeat (3) @(negedge clk);
      probe(32'hFE00_0000);
      probe(32'hFE00_1000);
      boot_pin = 1'b0;

      // Boot from flash
      do_reset(1'b1);
      sweep();

      // R10: pin dropped after reset, alias stays
      @(negedge clk);
      boot_pin = 1'b0;
      repeat (3) @(negedge clk);
      probe(32'hFE3F_FFFC);
      probe(32'hFE00_0800);

      @(negedge clk);
      valid = 1'b0;
      done  = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule